// File: doc/BRIEF.md
# Gapped-Clock Data Link Extractor

This block sits behind a receive framer on a 2.048 Mbit/s framed line. It watches the decoded line bit stream and the frame position reported by the framer. It copies a chosen group of spare bit positions out to a serial data-link output. Alongside that output it produces a clock that pulses only for the copied bits. The block runs entirely on the recovered line clock.

A downstream link device samples `dl_data` on each rising edge of `dl_clk` and sees nothing between pulses. The spare positions sit in timeslot 0 of the odd-numbered frames, in the bits that carry no frame alignment word. `rate_sel` sets how many of the five spare positions are taken, starting from the first one. Frames arrive at 8 kHz and only every second frame carries spare bits, so each enabled position adds 4 kHz. The resulting average link rate is 4, 8, 12, 16 or 20 kHz. While the framer reports loss of alignment, the extractor suspends output.

Top module: `dl_extract`

## Requirements
- R1: While `rst_n` is low and after its release, `dl_data` is 0 and `dl_clk` is low until the first selected bit.
- R2: A bit is selected when `lof` is 0, `frm_num[0]` is 1 (odd frame) and `bit_pos` lies in the range 3 to 2+N, where N is the effective rate setting. On the rising clock edge that sees a selected bit, `dl_data` takes the value of `line_bit`.
- R3: `dl_clk` is high only during the low phase of `clk` that follows a rising edge which sampled a selected bit. It is low for the whole of every other clock period.
- R4: In even frames (`frm_num[0]` = 0), no bit is selected, whatever the other inputs are.
- R5: The effective setting N equals `rate_sel` for values 0 to 5. A value of 0 selects nothing. Values 6 and 7 act as 5.
- R6: On an edge that sees no selected bit, `dl_data` keeps its previous value.
- R7: While `lof` is 1, `dl_clk` produces no pulse and `dl_data` holds its value.
- R8: Across one odd frame with `lof` = 0, `dl_clk` gives exactly N pulses, which is 4·N kHz on average.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered line clock |
| rst_n | input | 1 | Active-low reset |
| line_bit | input | 1 | Decoded received line bit for the current position |
| frm_num | input | 4 | Frame number 0–15; bit 0 high marks an odd frame |
| bit_pos | input | 8 | Bit index within the frame, 0–255 |
| lof | input | 1 | Loss of frame alignment from the framer |
| rate_sel | input | 3 | Number of spare positions taken (0–5, higher saturates at 5) |
| dl_data | output | 1 | Extracted data-link bit stream |
| dl_clk | output | 1 | Gapped clock, pulses mid-bit for each extracted bit |

## Verification
Every value of `rate_sel` from 0 to 7 is run across full odd and even frames with random line data. This separates the position window, the saturation above 5 and the all-off setting, and random data shows whether each bit is copied or held. Sections with alignment lost run the same odd frames, so suppression cannot be confused with window decode. The bit index is also swept to 255 so that positions beyond the window cannot alias into it.

// File: rtl/dl_extract.sv
module dl_extract #(
  parameter int BIT_W       = 8,
  parameter int FRM_W       = 4,
  parameter int SEL_W       = 3,
  parameter int SPARE_FIRST = 3,
  parameter int SPARE_MAX   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_bit,
  input  logic [FRM_W-1:0] frm_num,
  input  logic [BIT_W-1:0] bit_pos,
  input  logic             lof,
  input  logic [SEL_W-1:0] rate_sel,
  output logic             dl_data,
  output logic             dl_clk
);
  localparam int LIM_W = BIT_W + 1;

  logic [SEL_W-1:0] n_eff;
  logic [LIM_W-1:0] lim;
  logic             pick;
  logic             sel_q;

  assign n_eff = (rate_sel > SEL_W'(SPARE_MAX)) ? SEL_W'(SPARE_MAX) : rate_sel;
  assign lim   = LIM_W'(SPARE_FIRST) + LIM_W'(n_eff);
  assign pick  = !lof && frm_num[0]
               && ({1'b0, bit_pos} >= LIM_W'(SPARE_FIRST))
               && ({1'b0, bit_pos} < lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      dl_data <= 1'b0;
    end else begin
      sel_q <= pick;
      if (pick) dl_data <= line_bit;
    end
  end

  // pulse occupies the low half of the line clock after a selected edge
  assign dl_clk = sel_q & ~clk;

  p_even_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_num[0] |=> (!sel_q && $stable(dl_data)));

  p_lof_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lof |=> (!sel_q && $stable(dl_data)));

  p_zero_rate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == '0) |=> !sel_q);

  p_below_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_pos < BIT_W'(SPARE_FIRST)) |=> $stable(dl_data));

  p_beyond_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_pos >= BIT_W'(SPARE_FIRST + SPARE_MAX)) |=> !sel_q);

  p_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lof && frm_num[0] && bit_pos == BIT_W'(SPARE_FIRST) && rate_sel != '0)
      |=> (dl_data == $past(line_bit)));
endmodule

// File: tb/dl_extract_bench.sv
module dl_extract_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_bit = 1'b0;
  logic [3:0] frm_num = '0;
  logic [7:0] bit_pos = '0;
  logic       lof = 1'b0;
  logic [2:0] rate_sel = '0;
  logic       dl_data, dl_clk;

  int tests = 0;
  int fails = 0;
  logic exp_data = 1'b0;
  logic exp_sel  = 1'b0;
  int pulses = 0;

  always #2 clk = ~clk;

  dl_extract u_dl_extract (
    .clk(clk), .rst_n(rst_n), .line_bit(line_bit), .frm_num(frm_num),
    .bit_pos(bit_pos), .lof(lof), .rate_sel(rate_sel),
    .dl_data(dl_data), .dl_clk(dl_clk)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff_rate(input logic [2:0] r);
    return (r > 3'd5) ? 5 : int'(r);
  endfunction

  task automatic step(input logic lb, input logic [3:0] fn, input logic [7:0] bp,
                      input logic lf, input logic [2:0] rs);
    logic want;
    line_bit = lb; frm_num = fn; bit_pos = bp; lof = lf; rate_sel = rs;
    want = !lf && fn[0] && (int'(bp) >= 3) && (int'(bp) < 3 + eff_rate(rs));
    @(posedge clk);
    exp_sel = want;
    if (want) exp_data = lb;
    #1;
    chk(dl_data === exp_data, want ? "R2" : (lf ? "R7" : "R6"), int'(dl_data), int'(exp_data));
    chk(dl_clk === 1'b0, "R3", int'(dl_clk), 0);
    @(negedge clk); #1;
    chk(dl_clk === exp_sel, fn[0] ? (lf ? "R7" : "R5") : "R4", int'(dl_clk), int'(exp_sel));
    if (dl_clk === 1'b1) pulses++;
  endtask

  task automatic run_frame(input logic [3:0] fn, input logic lf, input logic [2:0] rs,
                           input int nbits);
    pulses = 0;
    for (int b = 0; b < nbits; b++) step(1'($urandom), fn, 8'(b), lf, rs);
    if (fn[0] && !lf)
      chk(pulses == eff_rate(rs), "R8", pulses, eff_rate(rs));
    else
      chk(pulses == 0, lf ? "R7" : "R4", pulses, 0);
  endtask

  initial begin
    bit fin = 0;
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
          fails++; tests++;
          $display("FAIL watchdog: actual 1 expected 0");
          $display("[TB] %0d tests run, %0d failed", tests, fails);
          $finish;
        end
      end
    join_none

    repeat (3) @(negedge clk);
    chk(dl_data === 1'b0, "R1", int'(dl_data), 0);
    chk(dl_clk === 1'b0, "R1", int'(dl_clk), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(dl_clk === 1'b0, "R1", int'(dl_clk), 0);

    for (int r = 0; r < 8; r++) begin
      for (int f = 0; f < 4; f++) run_frame(4'(f), 1'b0, 3'(r), 32);
    end
    run_frame(4'd1, 1'b1, 3'd5, 32);
    run_frame(4'd3, 1'b1, 3'd3, 32);
    run_frame(4'd5, 1'b0, 3'd2, 256);
    run_frame(4'd14, 1'b0, 3'd5, 16);
    run_frame(4'd15, 1'b0, 3'd7, 256);
    for (int k = 0; k < 20; k++)
      step(1'($urandom), 4'($urandom), 8'($urandom_range(0, 9)), 1'($urandom), 3'($urandom));

    fin = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule